// File: doc/BRIEF.md
# Multicycle Issue Hazard Gate

This block sits at the decode stage of an in-order, single-issue pipeline whose execution side has four paths of different length. These are a one-stage integer path (also used by loads and stores), a four-stage floating-point adder, a seven-stage multiplier and an unpipelined divider that holds one operation for 25 cycles. All four paths then pass through a shared memory stage and a single register write-back port.

Each cycle the block looks at the instruction that decode presents and decides whether it may leave decode. The instruction is held when any of four conditions applies: the divider is still occupied, the write-back cycle it would need is already taken, one of its sources is produced by an instruction whose result is not yet ready for forwarding, or its destination is also the destination of an adder, multiplier or divider operation still in progress. A held instruction sends a bubble forward and changes no tracking state. Every condition that applies raises its own reason flag.

Internally the block keeps a per-register countdown to operand readiness, the destinations sitting in each adder and multiplier stage, a divider occupancy counter and a shift-register map of future write-back cycles. The arithmetic itself is not part of the block.

Top module: `fp_issue_gate`

## Requirements
- R1: After reset no work is in flight: with `dec_valid` low, `issue_ok` and `stall` are both 0, and the first valid instruction of any unit issues.
- R2: The unit code picks the path: 0 integer, 1 load, 2 adder, 3 multiplier, 4 divider, and codes 5 to 7 behave as integer. An instruction issued in cycle t writes back in cycle t+3 for integer and load, t+6 for the adder, t+9 for the multiplier and t+27 for the divider.
- R3: An instruction with a destination is held (`stall_wb`) when an earlier issued instruction with a destination writes back in the same cycle as it would.
- R4: A source is ready for an instruction in decode cycle c when the most recently issued writer of that register issued in cycle t with c - t greater than its latency (integer 0, load 1, adder 3, multiplier 6, divider 24); otherwise the instruction is held (`stall_raw`).
- R5: An instruction with a destination is held (`stall_waw`) when the same register is the destination of an adder issued 1 to 4 cycles ago, a multiplier issued 1 to 7 cycles ago, or a divide issued 1 to 24 cycles ago.
- R6: A divide is held (`stall_div`) until 25 cycles have passed since the previous divide issued, so two divides issue at least 25 cycles apart.
- R7: `issue_ok` is 1 exactly when `dec_valid` is 1 and no reason flag is set; `stall` is `dec_valid` with any reason set; all flags are 0 when `dec_valid` is 0.
- R8: A held instruction leaves no trace: it occupies no divider time, reserves no write-back cycle and creates no pending destination.
- R9: An instruction with `dec_dst_en` low reserves no write-back cycle and creates no RAW or WAW dependence, though a divide without destination still occupies the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is waiting in decode |
| dec_unit | input | 3 | Execution path code of that instruction |
| dec_src1 | input | RBITS | First source register |
| dec_src1_en | input | 1 | First source is used |
| dec_src2 | input | RBITS | Second source register |
| dec_src2_en | input | 1 | Second source is used |
| dec_dst | input | RBITS | Destination register |
| dec_dst_en | input | 1 | Instruction writes a register |
| issue_ok | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held and a bubble goes forward |
| stall_div | output | 1 | Held because the divider is occupied |
| stall_wb | output | 1 | Held because its write-back cycle is taken |
| stall_raw | output | 1 | Held because a source is not ready |
| stall_waw | output | 1 | Held because its destination is pending in a long path |

## Verification
The embedded properties watch on every cycle that two divides never issue closer than 25 cycles, that each issue with a destination adds exactly one write-back reservation without disturbing others, that an adder result is never consumed the very next cycle, that a multiplier destination is never reused the next cycle, and that nothing issues or stalls without a valid instruction. Exact readiness windows per unit, write-back clashes between paths of different length, the effect of the most recent writer, and the absence of side effects from held or destination-less instructions can only be shown by the scenarios, where a bench model built from issue cycles predicts every flag.

// File: rtl/fp_issue_gate.sv
module fp_issue_gate #(
  parameter int RBITS      = 5,
  parameter int ADD_STAGES = 4,
  parameter int MUL_STAGES = 7,
  parameter int DIV_CYCLES = 25,
  parameter int LOAD_LAT   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [2:0]       dec_unit,
  input  logic [RBITS-1:0] dec_src1,
  input  logic             dec_src1_en,
  input  logic [RBITS-1:0] dec_src2,
  input  logic             dec_src2_en,
  input  logic [RBITS-1:0] dec_dst,
  input  logic             dec_dst_en,
  output logic             issue_ok,
  output logic             stall,
  output logic             stall_div,
  output logic             stall_wb,
  output logic             stall_raw,
  output logic             stall_waw
);

  localparam int NREG  = 1 << RBITS;
  localparam int D_INT = 3;
  localparam int D_ADD = ADD_STAGES + 2;
  localparam int D_MUL = MUL_STAGES + 2;
  localparam int D_DIV = DIV_CYCLES + 2;
  localparam int RES_W = D_DIV + 1;
  localparam int WBW   = $clog2(RES_W);
  localparam int CW    = $clog2(DIV_CYCLES + 1);

  localparam logic [2:0] U_LOAD = 3'd1;
  localparam logic [2:0] U_ADD  = 3'd2;
  localparam logic [2:0] U_MUL  = 3'd3;
  localparam logic [2:0] U_DIV  = 3'd4;

  logic [CW-1:0]    rdy_cnt [NREG];
  logic [CW-1:0]    div_cnt;
  logic [RBITS-1:0] div_dst;
  logic             div_dv;
  logic             add_v [ADD_STAGES];
  logic [RBITS-1:0] add_d [ADD_STAGES];
  logic             mul_v [MUL_STAGES];
  logic [RBITS-1:0] mul_d [MUL_STAGES];
  logic [RES_W-1:0] resv;

  logic [CW-1:0]    new_lat;
  logic [WBW-1:0]   new_wb;
  logic             raw_hit, waw_hit, fire;
  logic [RES_W-1:0] resv_add;

  always_comb begin
    case (dec_unit)
      U_LOAD:  begin new_lat = CW'(LOAD_LAT);       new_wb = WBW'(D_INT); end
      U_ADD:   begin new_lat = CW'(ADD_STAGES - 1); new_wb = WBW'(D_ADD); end
      U_MUL:   begin new_lat = CW'(MUL_STAGES - 1); new_wb = WBW'(D_MUL); end
      U_DIV:   begin new_lat = CW'(DIV_CYCLES - 1); new_wb = WBW'(D_DIV); end
      default: begin new_lat = '0;                  new_wb = WBW'(D_INT); end
    endcase
  end

  assign raw_hit = (dec_src1_en && rdy_cnt[dec_src1] != '0) ||
                   (dec_src2_en && rdy_cnt[dec_src2] != '0);

  always_comb begin
    waw_hit = (div_cnt != '0) && div_dv && (div_dst == dec_dst);
    for (int i = 0; i < ADD_STAGES; i++)
      if (add_v[i] && add_d[i] == dec_dst) waw_hit = 1'b1;
    for (int i = 0; i < MUL_STAGES; i++)
      if (mul_v[i] && mul_d[i] == dec_dst) waw_hit = 1'b1;
  end

  assign stall_div = dec_valid && dec_unit == U_DIV && div_cnt != '0;
  assign stall_wb  = dec_valid && dec_dst_en && resv[new_wb];
  assign stall_raw = dec_valid && raw_hit;
  assign stall_waw = dec_valid && dec_dst_en && waw_hit;
  assign stall     = stall_div | stall_wb | stall_raw | stall_waw;
  assign issue_ok  = dec_valid && rst_n && !stall;
  assign fire      = issue_ok;

  assign resv_add = (fire && dec_dst_en) ? (RES_W'(1) << (new_wb - WBW'(1))) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rdy_cnt[r] <= '0;
      for (int i = 0; i < ADD_STAGES; i++) begin add_v[i] <= 1'b0; add_d[i] <= '0; end
      for (int i = 0; i < MUL_STAGES; i++) begin mul_v[i] <= 1'b0; mul_d[i] <= '0; end
      div_cnt <= '0;
      div_dst <= '0;
      div_dv  <= 1'b0;
      resv    <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (fire && dec_dst_en && dec_dst == RBITS'(r)) rdy_cnt[r] <= new_lat;
        else if (rdy_cnt[r] != '0)                      rdy_cnt[r] <= rdy_cnt[r] - CW'(1);
      end
      add_v[0] <= fire && dec_dst_en && dec_unit == U_ADD;
      add_d[0] <= dec_dst;
      for (int i = 1; i < ADD_STAGES; i++) begin add_v[i] <= add_v[i-1]; add_d[i] <= add_d[i-1]; end
      mul_v[0] <= fire && dec_dst_en && dec_unit == U_MUL;
      mul_d[0] <= dec_dst;
      for (int i = 1; i < MUL_STAGES; i++) begin mul_v[i] <= mul_v[i-1]; mul_d[i] <= mul_d[i-1]; end
      if (fire && dec_unit == U_DIV) begin
        div_cnt <= CW'(DIV_CYCLES - 1);
        div_dst <= dec_dst;
        div_dv  <= dec_dst_en;
      end else if (div_cnt != '0) begin
        div_cnt <= div_cnt - CW'(1);
      end
      resv <= (resv >> 1) | resv_add;
    end
  end

  logic [CW-1:0] since_div;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_div <= CW'(DIV_CYCLES);
    else if (fire && dec_unit == U_DIV)  since_div <= CW'(1);
    else if (since_div < CW'(DIV_CYCLES)) since_div <= since_div + CW'(1);
  end

  a_r6_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec_unit == U_DIV) |-> since_div >= CW'(DIV_CYCLES));

  a_r3_one_new_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec_dst_en) |=> $countones(resv) == $countones($past(resv) >> 1) + 1);

  a_r4_add_not_forwarded_next: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec_dst_en && dec_unit == U_ADD) |=>
      !(issue_ok && dec_src1_en && dec_src1 == $past(dec_dst)));

  a_r5_mul_dst_reuse: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec_dst_en && dec_unit == U_MUL) |=>
      !(issue_ok && dec_dst_en && dec_dst == $past(dec_dst)));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!issue_ok && !stall));

endmodule

// File: tb/fp_issue_gate_tb.sv
module fp_issue_gate_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_valid = 1'b0;
  logic [2:0] dec_unit = '0;
  logic [4:0] dec_src1 = '0, dec_src2 = '0, dec_dst = '0;
  logic       dec_src1_en = 1'b0, dec_src2_en = 1'b0, dec_dst_en = 1'b0;
  logic       issue_ok, stall, stall_div, stall_wb, stall_raw, stall_waw;

  always #2.5 clk = ~clk;

  fp_issue_gate u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
    .dec_src1(dec_src1), .dec_src1_en(dec_src1_en),
    .dec_src2(dec_src2), .dec_src2_en(dec_src2_en),
    .dec_dst(dec_dst), .dec_dst_en(dec_dst_en),
    .issue_ok(issue_ok), .stall(stall), .stall_div(stall_div),
    .stall_wb(stall_wb), .stall_raw(stall_raw), .stall_waw(stall_waw));

  int vectors = 0, fails = 0, cyc = 0, nissued = 0;
  bit done = 0;
  bit last_stall = 0;

  int       e_t  [64];
  int       e_u  [64];
  int       e_d  [64];
  bit       e_de [64];
  bit       e_v  [64];

  function automatic int wb_of(int u);
    case (u) 2: return 6; 3: return 9; 4: return 27; default: return 3; endcase
  endfunction

  function automatic int lat_of(int u);
    case (u) 1: return 1; 2: return 3; 3: return 6; 4: return 24; default: return 0; endcase
  endfunction

  function automatic bit src_busy(int s);
    int best = -1;
    int bt = -1000;
    for (int k = 0; k < 64; k++)
      if (e_v[k] && e_de[k] && e_d[k] == s && e_t[k] > bt) begin bt = e_t[k]; best = k; end
    if (best < 0) return 0;
    return (cyc - bt) <= lat_of(e_u[best]);
  endfunction

  task automatic chk(string what, bit act, bit exp, string scen);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (scenario %s) cycle %0d: actual %0b expected %0b", what, scen, cyc, act, exp);
    end
  endtask

  task automatic step(bit v, int u, int s1, bit s1e, int s2, bit s2e, int d, bit de, string scen);
    bit xd, xw, xr, xa, xf;
    @(negedge clk);
    dec_valid = v; dec_unit = 3'(u);
    dec_src1 = 5'(s1); dec_src1_en = s1e; dec_src2 = 5'(s2); dec_src2_en = s2e;
    dec_dst = 5'(d); dec_dst_en = de;
    #1;
    xd = 0; xw = 0; xr = 0; xa = 0;
    for (int k = 0; k < 64; k++) begin
      if (e_v[k] && cyc - e_t[k] > 40) e_v[k] = 0;
      if (e_v[k]) begin
        if (e_u[k] == 4 && cyc - e_t[k] <= 24) xd = 1;
        if (de && e_de[k] && e_t[k] + wb_of(e_u[k]) == cyc + wb_of(u)) xw = 1;
        if (de && e_de[k] && e_d[k] == d &&
            ((e_u[k] == 2 && cyc - e_t[k] <= 4) || (e_u[k] == 3 && cyc - e_t[k] <= 7) ||
             (e_u[k] == 4 && cyc - e_t[k] <= 24))) xa = 1;
      end
    end
    xd = xd && (u == 4);
    if ((s1e && src_busy(s1)) || (s2e && src_busy(s2))) xr = 1;
    xd = xd && v; xw = xw && v; xr = xr && v; xa = xa && v;
    xf = v && !(xd || xw || xr || xa);
    vectors++;
    chk("R7 issue_ok", issue_ok, xf, scen);
    chk("R7 stall", stall, v && !xf, scen);
    chk("R6 stall_div", stall_div, xd, scen);
    chk("R3 stall_wb", stall_wb, xw, scen);
    chk("R4 stall_raw", stall_raw, xr, scen);
    chk("R5 stall_waw", stall_waw, xa, scen);
    last_stall = v && !xf;
    if (xf) begin
      e_t[nissued % 64] = cyc; e_u[nissued % 64] = u; e_d[nissued % 64] = d;
      e_de[nissued % 64] = de; e_v[nissued % 64] = 1;
      nissued++;
    end
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "drain");
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int cu, c1, c2, cd;
    bit c1e, c2e, cde, cv;
    int rs;
    rs = $urandom(32'h5eed);
    for (int k = 0; k < 64; k++) e_v[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, then first instruction issues
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 3, 1, 1, 2, 1, 3, 1, "R1");
    idle(30);

    // R2: integer result usable next cycle; adder vs later integer write-back clash
    step(1, 0, 0, 0, 0, 0, 4, 1, "R2");
    step(1, 0, 4, 1, 0, 0, 5, 1, "R2");
    step(1, 2, 0, 0, 0, 0, 6, 1, "R2");
    idle(2);
    step(1, 0, 0, 0, 0, 0, 7, 1, "R2");
    step(1, 0, 0, 0, 0, 0, 7, 1, "R2");
    idle(30);

    // R6: second divide waits 25 cycles
    step(1, 4, 0, 0, 0, 0, 10, 1, "R6");
    for (int i = 0; i < 26; i++) step(1, 4, 0, 0, 0, 0, 11, 1, "R6");
    idle(30);

    // R3: multiplier then adder three cycles later share write-back cycle
    step(1, 3, 0, 0, 0, 0, 1, 1, "R3");
    idle(2);
    step(1, 2, 0, 0, 0, 0, 2, 1, "R3");
    step(1, 2, 0, 0, 0, 0, 2, 1, "R3");
    idle(30);

    // R4: load-use and adder-use windows
    step(1, 1, 0, 0, 0, 0, 3, 1, "R4");
    for (int i = 0; i < 2; i++) step(1, 0, 3, 1, 0, 0, 12, 1, "R4");
    step(1, 2, 0, 0, 0, 0, 4, 1, "R4");
    for (int i = 0; i < 5; i++) step(1, 3, 0, 0, 4, 1, 13, 1, "R4");
    idle(30);

    // R5: adder reusing a pending multiplier destination
    step(1, 3, 0, 0, 0, 0, 5, 1, "R5");
    for (int i = 0; i < 9; i++) step(1, 2, 0, 0, 0, 0, 5, 1, "R5");
    idle(30);

    // R9: destination-less multiplier leaves register 6 free
    step(1, 3, 0, 0, 0, 0, 6, 0, "R9");
    step(1, 2, 6, 1, 0, 0, 6, 1, "R9");
    idle(30);

    // R8: a held divide leaves no pending destination
    step(1, 4, 0, 0, 0, 0, 14, 1, "R8");
    step(1, 4, 0, 0, 0, 0, 9, 1, "R8");
    step(1, 0, 9, 1, 0, 0, 15, 1, "R8");
    step(1, 2, 0, 0, 0, 0, 9, 1, "R8");
    idle(30);

    cv = 0; cu = 0; c1 = 0; c2 = 0; cd = 0; c1e = 0; c2e = 0; cde = 0;
    for (int n = 0; n < 3000; n++) begin
      if (!(last_stall && ($urandom % 5) != 0)) begin
        cv  = ($urandom % 100) < 85;
        cu  = ($urandom % 10);
        cu  = (cu < 3) ? 0 : (cu < 5) ? 1 : (cu < 7) ? 2 : (cu < 9) ? 3 : 4;
        c1  = $urandom % 8; c2 = $urandom % 8; cd = $urandom % 8;
        c1e = ($urandom % 4) != 0; c2e = ($urandom % 2) != 0;
        cde = ($urandom % 8) != 0;
      end
      step(cv, cu, c1, c1e, c2, c2e, cd, cde, "random R2 R3 R4 R5 R6 R7 R8 R9");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule